// File: doc/BRIEF.md
# Single-Channel DMA Word Mover

This block is a one-channel DMA engine for a 16-bit host processor. The host sets it up with a short series of output words and control commands on its I/O bus. A configuration word, sent to the channel's own configuration select code, names the peripheral to serve and says whether that peripheral's control bit is dropped when the block ends. On the channel's register select code, a clear-control command routes the next output word into the memory address register. That word also sets the transfer direction. A set-control command routes the next output word into the word-count register instead. The count is loaded as the negated number of words.

A set-control command with the flag-clear qualifier, sent to the configuration select code, arms the channel. While the channel is armed, each one-cycle service request from the peripheral moves one word. In that same cycle the block drives a memory strobe with the address, the write enable and the data. The word comes either from the peripheral into memory or from memory to the peripheral. After each word the address and the count both step up by one. On the word where the count wraps to zero, the channel disarms and raises a done flag. If the configuration asked for it, the block also pulses a request to clear the peripheral's control bit.

Top module: `dma_word_channel`

## Requirements
- R1: After reset, busy, done, mem_req, dev_wstb and dev_clr_ctl are all 0.
- R2: An output word to select code CFG_SC (default 6) loads dev_sel from its bits 5..0 and the auto-clear option from its bit 13. It also disarms the channel.
- R3: After a clear-control command to select code REG_SC (default 2), an output word to REG_SC loads the start address from bits 14..0 and the direction from bit 15. Bit 15 = 1 means device-to-memory (mem_we = 1); 0 means memory-to-device. Reset leaves this routing selected.
- R4: After a set-control command to REG_SC, an output word to REG_SC loads the count from bits 13..0. Bits 15..14 are ignored. A block moves 2^14 minus that field words.
- R5: A set-control command to CFG_SC with io_clf = 1 arms the channel (busy = 1). The same command with io_clf = 0 does not arm it. A service request while the channel is not armed produces no memory strobe.
- R6: While the channel is armed, svc_req produces mem_req in the same cycle, with mem_addr and mem_we valid. Device-to-memory: mem_wdata equals dev_rdata. Memory-to-device: dev_wstb = 1 and dev_wdata equals mem_rdata.
- R7: Each moved word advances the memory address by one, wrapping from 0x7FFF to 0x0000.
- R8: On the word where the count wraps to zero, busy falls and done rises at the following edge. Later service requests are ignored.
- R9: If auto-clear is set, dev_clr_ctl is a one-cycle pulse in the cycle after the final word. If it is clear, dev_clr_ctl stays 0.
- R10: done stays set until the next output word to CFG_SC or REG_SC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_sel | input | 6 | Select code addressed by the current host I/O operation |
| io_data | input | 16 | Host output word |
| io_out | input | 1 | Host output-word strobe |
| io_clc | input | 1 | Host clear-control command strobe |
| io_stc | input | 1 | Host set-control command strobe |
| io_clf | input | 1 | Flag-clear qualifier on a set-control command |
| svc_req | input | 1 | One-cycle service request from the selected peripheral |
| dev_rdata | input | 16 | Word offered by the peripheral (device-to-memory) |
| mem_rdata | input | 16 | Memory read data, valid in the strobe cycle |
| mem_req | output | 1 | Memory strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| dev_wstb | output | 1 | Word-to-peripheral strobe (memory-to-device) |
| dev_wdata | output | 16 | Word sent to the peripheral |
| dev_sel | output | 6 | Select code of the served peripheral |
| dev_clr_ctl | output | 1 | Pulse requesting the peripheral's control bit be cleared |
| busy | output | 1 | Channel armed |
| done | output | 1 | Block complete |

## Verification
The bench builds the block with its default parameters: a 15-bit address, a 14-bit count and select codes 6 and 2. Because the count is negated, blocks of three words and of one word reach the terminal wrap within a few cycles. A start address of 0x7FFE brings the address roll-over at 0x7FFF within reach of a three-word block. Both directions are run, each with and without auto-clear, and back-to-back service requests test the per-cycle stepping.

// File: rtl/dma_chan_pkg.sv
// Package: shared types for the single-channel DMA word mover.
// Assumes: nothing beyond IEEE 1800-2017.
package dma_chan_pkg;

    // Destination of the next output word on the register select code.
    typedef enum logic {
        STEER_ADDR = 1'b0,
        STEER_CNT  = 1'b1
    } steer_t;

endpackage

// File: rtl/dma_host_decode.sv
// Module: dma_host_decode
// Turns host I/O strobes into load and arm pulses for the channel.
// It keeps a one-bit routing state that clear-control and set-control
// commands on REG_SC set, and that output words on REG_SC follow.
// Assumes at most one of io_out/io_clc/io_stc is high in a cycle.
module dma_host_decode
    import dma_chan_pkg::*;
#(
    parameter int SC_W   = 6,
    parameter int CFG_SC = 6,
    parameter int REG_SC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SC_W-1:0] io_sel,
    input  logic            io_out,
    input  logic            io_clc,
    input  logic            io_stc,
    input  logic            io_clf,
    output logic            ld_cfg,
    output logic            ld_addr,
    output logic            ld_cnt,
    output logic            arm
);

    localparam logic [SC_W-1:0] CFG_CODE = SC_W'(CFG_SC);
    localparam logic [SC_W-1:0] REG_CODE = SC_W'(REG_SC);

    steer_t steer_q;
    logic   hit_cfg;
    logic   hit_reg;

    // Compare the addressed select code with the two channel codes.
    always_comb begin
        hit_cfg = (io_sel == CFG_CODE);
        hit_reg = (io_sel == REG_CODE);
    end

    // Keep the routing state that the control commands set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steer_q <= STEER_ADDR;
        end else if (hit_reg && io_clc) begin
            steer_q <= STEER_ADDR;
        end else if (hit_reg && io_stc) begin
            steer_q <= STEER_CNT;
        end
    end

    // Produce the load and arm pulses.
    always_comb begin
        ld_cfg  = io_out && hit_cfg;
        ld_addr = io_out && hit_reg && (steer_q == STEER_ADDR);
        ld_cnt  = io_out && hit_reg && (steer_q == STEER_CNT);
        arm     = io_stc && io_clf && hit_cfg;
    end

    AST_CLC_ROUTES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_reg && io_clc) |=> (steer_q == STEER_ADDR)); // R3

    AST_STC_ROUTES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_reg && io_stc && !io_clc) |=> (steer_q == STEER_CNT)); // R4

endmodule

// File: rtl/dma_xfer_engine.sv
// Module: dma_xfer_engine
// Holds the channel state: peripheral select, auto-clear option,
// address, direction and negated count. It arms, steps once per
// service request and completes when the count wraps to zero.
// Assumes loads and arm come from dma_host_decode as single pulses.
module dma_xfer_engine #(
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 15,
    parameter int CNT_W        = 14,
    parameter int SC_W         = 6,
    parameter int DIR_BIT      = 15,
    parameter int AUTO_CLR_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] io_data,
    input  logic              ld_cfg,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic              arm,
    input  logic              svc_req,
    output logic              word_go,
    output logic [ADDR_W-1:0] addr,
    output logic              dir_to_mem,
    output logic [SC_W-1:0]   dev_sel,
    output logic              busy,
    output logic              done,
    output logic              clr_pulse
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SC_W-1:0]   sel_q;
    logic              dir_q;
    logic              auto_clr_q;
    logic              busy_q;
    logic              done_q;
    logic              clr_q;
    logic              last_word;
    logic              any_load;

    // Decide when a word moves and whether it is the final one.
    always_comb begin
        word_go   = busy_q && svc_req;
        last_word = word_go && (&cnt_q);
        any_load  = ld_cfg || ld_addr || ld_cnt;
    end

    // Configuration word: peripheral select and auto-clear option.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q      <= '0;
            auto_clr_q <= 1'b0;
        end else if (ld_cfg) begin
            sel_q      <= io_data[SC_W-1:0];
            auto_clr_q <= io_data[AUTO_CLR_BIT];
        end
    end

    // Address and direction: load, then step by one per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            dir_q  <= 1'b0;
        end else if (ld_addr) begin
            addr_q <= io_data[ADDR_W-1:0];
            dir_q  <= io_data[DIR_BIT];
        end else if (word_go) begin
            addr_q <= addr_q + ADDR_ONE;
        end
    end

    // Negated word count: load, then step up toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_cnt) begin
            cnt_q <= io_data[CNT_W-1:0];
        end else if (word_go) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    // Armed state: set by arm, dropped by config load or completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (arm) begin
            busy_q <= 1'b1;
        end else if (ld_cfg || last_word) begin
            busy_q <= 1'b0;
        end
    end

    // Sticky completion flag, cleared by any register load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (any_load) begin
            done_q <= 1'b0;
        end else if (last_word) begin
            done_q <= 1'b1;
        end
    end

    // One-cycle control-clear request after the final word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q <= 1'b0;
        end else begin
            clr_q <= last_word && auto_clr_q;
        end
    end

    // Drive outputs from state.
    always_comb begin
        addr       = addr_q;
        dir_to_mem = dir_q;
        dev_sel    = sel_q;
        busy       = busy_q;
        done       = done_q;
        clr_pulse  = clr_q;
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_go && !ld_addr) |=> (addr_q == $past(addr_q) + ADDR_ONE)); // R7

    AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (last_word && !arm && !any_load) |=> (done_q && !busy_q)); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !any_load) |=> done_q); // R10

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |=> !clr_q); // R9

endmodule

// File: rtl/dma_word_channel.sv
// Module: dma_word_channel (top)
// Single-channel DMA word mover. The host programs it through I/O
// strobes; each peripheral service request then moves one word between
// memory and the peripheral in the request cycle.
// Assumes memory read data is valid combinationally in the strobe cycle.
module dma_word_channel #(
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 15,
    parameter int CNT_W        = 14,
    parameter int SC_W         = 6,
    parameter int CFG_SC       = 6,
    parameter int REG_SC       = 2,
    parameter int DIR_BIT      = 15,
    parameter int AUTO_CLR_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SC_W-1:0]   io_sel,
    input  logic [DATA_W-1:0] io_data,
    input  logic              io_out,
    input  logic              io_clc,
    input  logic              io_stc,
    input  logic              io_clf,
    input  logic              svc_req,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dev_wstb,
    output logic [DATA_W-1:0] dev_wdata,
    output logic [SC_W-1:0]   dev_sel,
    output logic              dev_clr_ctl,
    output logic              busy,
    output logic              done
);

    logic ld_cfg;
    logic ld_addr;
    logic ld_cnt;
    logic arm;
    logic word_go;
    logic dir_to_mem;

    dma_host_decode #(
        .SC_W   (SC_W),
        .CFG_SC (CFG_SC),
        .REG_SC (REG_SC)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_sel  (io_sel),
        .io_out  (io_out),
        .io_clc  (io_clc),
        .io_stc  (io_stc),
        .io_clf  (io_clf),
        .ld_cfg  (ld_cfg),
        .ld_addr (ld_addr),
        .ld_cnt  (ld_cnt),
        .arm     (arm)
    );

    dma_xfer_engine #(
        .DATA_W       (DATA_W),
        .ADDR_W       (ADDR_W),
        .CNT_W        (CNT_W),
        .SC_W         (SC_W),
        .DIR_BIT      (DIR_BIT),
        .AUTO_CLR_BIT (AUTO_CLR_BIT)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_data    (io_data),
        .ld_cfg     (ld_cfg),
        .ld_addr    (ld_addr),
        .ld_cnt     (ld_cnt),
        .arm        (arm),
        .svc_req    (svc_req),
        .word_go    (word_go),
        .addr       (mem_addr),
        .dir_to_mem (dir_to_mem),
        .dev_sel    (dev_sel),
        .busy       (busy),
        .done       (done),
        .clr_pulse  (dev_clr_ctl)
    );

    // Memory strobe and the data path in the strobe cycle.
    always_comb begin
        mem_req   = word_go;
        mem_we    = dir_to_mem;
        mem_wdata = dev_rdata;
        dev_wstb  = word_go && !dir_to_mem;
        dev_wdata = mem_rdata;
    end

    AST_NO_STROBE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !done); // R8

    AST_STROBE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> svc_req); // R6

endmodule

// File: tb/dma_word_channel_tb_top.sv
`timescale 1ns/1ps
module dma_word_channel_tb_top;

    localparam int CFG = 6;
    localparam int REG = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  io_sel = '0;
    logic [15:0] io_data = '0;
    logic        io_out = 1'b0;
    logic        io_clc = 1'b0;
    logic        io_stc = 1'b0;
    logic        io_clf = 1'b0;
    logic        svc_req = 1'b0;
    logic [15:0] dev_rdata = '0;
    logic [15:0] mem_rdata = '0;
    logic        mem_req;
    logic        mem_we;
    logic [14:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        dev_wstb;
    logic [15:0] dev_wdata;
    logic [5:0]  dev_sel;
    logic        dev_clr_ctl;
    logic        busy;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [14:0] a;
        logic        we;
        logic [15:0] d;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    dma_word_channel dut_i (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_data(io_data),
        .io_out(io_out), .io_clc(io_clc), .io_stc(io_stc), .io_clf(io_clf),
        .svc_req(svc_req), .dev_rdata(dev_rdata), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .dev_wstb(dev_wstb), .dev_wdata(dev_wdata),
        .dev_sel(dev_sel), .dev_clr_ctl(dev_clr_ctl), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic io_write(input int sc, input logic [15:0] d);
        io_sel = 6'(sc); io_data = d; io_out = 1'b1;
        tick();
        io_out = 1'b0;
    endtask

    task automatic io_clear(input int sc);
        io_sel = 6'(sc); io_clc = 1'b1;
        tick();
        io_clc = 1'b0;
    endtask

    task automatic io_set(input int sc, input bit clf);
        io_sel = 6'(sc); io_stc = 1'b1; io_clf = clf;
        tick();
        io_stc = 1'b0; io_clf = 1'b0;
    endtask

    // Driver: one service request, expected strobe pushed to scoreboard.
    task automatic service(input logic [15:0] v, input logic [14:0] ea, input logic ewe, input string tag);
        exp_t e;
        dev_rdata = v;
        mem_rdata = v ^ 16'h5A5A;
        e.a = ea; e.we = ewe; e.d = ewe ? v : (v ^ 16'h5A5A); e.tag = tag;
        exp_q.push_back(e);
        svc_req = 1'b1;
        tick();
        svc_req = 1'b0;
    endtask

    // A service request that must produce no strobe.
    task automatic ignored_service(input string tag);
        svc_req = 1'b1;
        @(negedge clk);
        check(mem_req == 1'b0, tag, 32'(mem_req), 32'h0);
        tick();
        svc_req = 1'b0;
    endtask

    // Monitor: pop and compare every strobe the design produces.
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R5/R8 unexpected strobe actual=%0h expected=none", mem_addr);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(mem_addr == e.a, {e.tag, " R7 address"}, 32'(mem_addr), 32'(e.a));
                check(mem_we == e.we, {e.tag, " R3 direction"}, 32'(mem_we), 32'(e.we));
                check(dev_wstb == !e.we, {e.tag, " R6 device strobe"}, 32'(dev_wstb), 32'(!e.we));
                if (e.we)
                    check(mem_wdata == e.d, {e.tag, " R6 memory data"}, 32'(mem_wdata), 32'(e.d));
                else
                    check(dev_wdata == e.d, {e.tag, " R6 device data"}, 32'(dev_wdata), 32'(e.d));
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(busy == 0 && done == 0 && dev_clr_ctl == 0, "R1 idle after reset", {busy, done, dev_clr_ctl}, 0);
        check(mem_req == 0 && dev_wstb == 0, "R1 no strobes", {mem_req, dev_wstb}, 0);

        // R2 configuration: select 012 octal, auto-clear set
        io_write(CFG, 16'o020012);
        check(dev_sel == 6'o12, "R2 select code", 32'(dev_sel), 32'o12);

        // R3 address 0x0100 device-to-memory; R4 count -3 with junk in 15..14
        io_clear(REG);
        io_write(REG, 16'h8100);
        io_set(REG, 1'b0);
        io_write(REG, 16'hFFFD);

        // R5 not armed yet, and flag-clear missing does not arm
        ignored_service("R5 request before arm");
        io_set(CFG, 1'b0);
        check(busy == 0, "R5 no arm without flag clear", 32'(busy), 0);
        io_set(CFG, 1'b1);
        check(busy == 1, "R5 armed", 32'(busy), 1);

        // R6/R7 three words with gaps
        service(16'h1111, 15'h0100, 1'b1, "blk1 w0");
        tick();
        service(16'h2222, 15'h0101, 1'b1, "blk1 w1");
        check(busy == 1 && done == 0, "R4 still running after two words", {busy, done}, 2'b10);
        tick();
        service(16'h3333, 15'h0102, 1'b1, "blk1 w2");
        check(done == 1 && busy == 0, "R8 complete after third word", {done, busy}, 2'b10);
        check(dev_clr_ctl == 1, "R9 clear pulse", 32'(dev_clr_ctl), 1);
        tick();
        check(dev_clr_ctl == 0, "R9 pulse one cycle", 32'(dev_clr_ctl), 0);
        ignored_service("R8 request after done");
        repeat (3) tick();
        check(done == 1, "R10 done sticky", 32'(done), 1);

        // Memory-to-device, no auto-clear, address wrap
        io_write(CFG, 16'o000005);
        check(done == 0, "R10 done cleared by load", 32'(done), 0);
        check(dev_sel == 6'o05, "R2 select reload", 32'(dev_sel), 32'o05);
        io_clear(REG);
        io_write(REG, 16'h7FFE);
        io_set(REG, 1'b0);
        io_write(REG, 16'h3FFD);
        io_set(CFG, 1'b1);
        service(16'hA001, 15'h7FFE, 1'b0, "blk2 w0");
        service(16'hA002, 15'h7FFF, 1'b0, "blk2 w1");
        service(16'hA003, 15'h0000, 1'b0, "blk2 w2 wrap");
        check(done == 1 && busy == 0, "R8 block two complete", {done, busy}, 2'b10);
        check(dev_clr_ctl == 0, "R9 no pulse when option clear", 32'(dev_clr_ctl), 0);
        tick();
        check(dev_clr_ctl == 0, "R9 still no pulse", 32'(dev_clr_ctl), 0);

        // Single-word block; count reload via set-control routing (R4)
        io_write(CFG, 16'o020007);
        io_clear(REG);
        io_write(REG, 16'h8200);
        io_set(REG, 1'b0);
        io_write(REG, 16'h3FFF);
        io_set(CFG, 1'b1);
        service(16'h0BEE, 15'h0200, 1'b1, "blk3 single");
        check(done == 1 && busy == 0, "R4 one-word block ends", {done, busy}, 2'b10);
        check(dev_clr_ctl == 1 && dev_sel == 6'o07, "R9 pulse with select", {dev_clr_ctl, dev_sel}, {1'b1, 6'o07});
        ignored_service("R8 ignored after single word");

        tick();
        check(exp_q.size() == 0, "R6 all expected strobes seen", 32'(exp_q.size()), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule